// File: doc/BRIEF.md
# Two-Phase Overlapped Microinstruction Executor

This block runs the datapath half of a microcoded processor. On each clock it accepts one microinstruction, already decoded into control fields. The microinstruction executes in two phases. In its first cycle it may load one ALU operand register, T1 or T2. The value comes either from a read port of an 8-entry register bank or straight from the unregistered data input. In the next cycle the selected ALU function is applied to T1 and T2. The result goes to a register bank entry and/or the data output register, and the status flags are updated under a write mask.

The two phases overlap. While one microinstruction is in its second phase, the next one is already in its first phase. The second-phase fields are held in a pipeline register captured at the end of the first phase. Results are not forwarded, so microcode must leave a gap before it reads a register it has just written. The block also times the read, write and io bus strobes, can clear T1 at the end of the first phase, and can force a carry-in for increments. Sequencing and the control store live elsewhere.

Top module: `uop_exec`

## Requirements
- R1: When `ld_en` is 1 in a cycle, the operand register chosen by `ld_sel_t2` (0 = T1, 1 = T2) takes, at the end of that cycle, `din` if `ld_from_din` is 1, or otherwise register bank entry `rd_addr`. The other operand register keeps its value.
- R2: The ALU function, destinations and flag class given in cycle n are applied at the end of cycle n+1, using the T1/T2 values present in cycle n+1. A new microinstruction may be issued every cycle.
- R3: A register bank write made in the second phase of one microinstruction is not visible to the first phase of the microinstruction issued in the following cycle; that read returns the old entry.
- R4: `clr_t1` sets T1 to zero at the end of the first phase, and this takes priority over a load into T1 in the same cycle.
- R5: `set_ac` makes the carry-in of that microinstruction's ADD equal to 1, so that ADD with T2 = 0 increments T1.
- R6: `alu_op` encoding: 0 = T1, 1 = T2, 2 = T1+T2+carry-in (carry-in from R5), 3 = T1+T2+C flag, 4 = AND, 5 = OR, 6 = XOR, 7 = NOT T1.
- R7: `flags` = {S, Z, AC, P, C} at bits 4..0. S is result bit 7, Z is set when the result is zero, P is set for even parity, AC is the carry out of bit 3 and C is the carry out of bit 7 for ops 2 and 3. AC and C are 0 for all other ops.
- R8: `flag_cls` encoding: 1 writes S, Z, AC and P and keeps C; 2 writes only C; 3 writes all five flags.
- R9: With `flag_cls` = 0, the flags keep their values.
- R10: `rd_o` and `wr_o` are high in the cycle after the one in which `rd` / `wr` were given. `io_o` follows `io` in the same cycle.
- R11: During and after reset, `dout`, `flags`, the strobes, T1, T2 and every register bank entry are zero, and no second phase is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | First phase: load an operand register |
| ld_sel_t2 | input | 1 | Operand target: 0 = T1, 1 = T2 |
| ld_from_din | input | 1 | Operand source: 1 = din, 0 = register bank |
| rd_addr | input | 3 | Register bank read address |
| din | input | 8 | Unregistered data input |
| clr_t1 | input | 1 | Zero T1 at end of first phase |
| set_ac | input | 1 | Force ADD carry-in to 1 |
| io | input | 1 | io strobe request (first phase) |
| rd | input | 1 | Read strobe request (second phase) |
| wr | input | 1 | Write strobe request (second phase) |
| alu_op | input | 3 | ALU function for the second phase |
| wb_reg_en | input | 1 | Write the result to the register bank |
| wb_addr | input | 3 | Register bank write address |
| wb_dout | input | 1 | Write the result to dout |
| flag_cls | input | 2 | Flag write class |
| dout | output | 8 | Data output register |
| flags | output | 5 | {S, Z, AC, P, C} |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| io_o | output | 1 | io strobe |

## Verification
The hardest case to reach is a register write in the second phase that meets a read of the same entry in the next microinstruction's first phase, with flag classes changing at the same time. Only back-to-back issue produces this overlap. The bench drives directed pairs that write an entry and read it on the very next cycle, then reads it again after a gap. A long run of random microinstructions issued every cycle then covers the other overlaps, and a behavioural model that queues the pending second phase checks the outputs on every clock.

// File: rtl/uop_exec.sv
module uop_exec #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel_t2,
  input  logic          ld_from_din,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] din,
  input  logic          clr_t1,
  input  logic          set_ac,
  input  logic          io,
  input  logic          rd,
  input  logic          wr,
  input  logic [2:0]    alu_op,
  input  logic          wb_reg_en,
  input  logic [AW-1:0] wb_addr,
  input  logic          wb_dout,
  input  logic [1:0]    flag_cls,
  output logic [DW-1:0] dout,
  output logic [4:0]    flags,
  output logic          rd_o,
  output logic          wr_o,
  output logic          io_o
);

  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] t1, t2;

  logic          p2_cin1, p2_wb_reg, p2_wb_dout;
  logic [2:0]    p2_op;
  logic [AW-1:0] p2_addr;
  logic [1:0]    p2_cls;

  logic [DW-1:0] opnd;
  logic [DW:0]   sum;
  logic [4:0]    nib;
  logic          cin, is_add;
  logic [DW-1:0] res;
  logic [4:0]    fnew;

  assign opnd   = ld_from_din ? din : bank[rd_addr];
  assign io_o   = rst_n & io;

  assign is_add = (p2_op == 3'd2) || (p2_op == 3'd3);
  assign cin    = (p2_op == 3'd3) ? flags[0] : p2_cin1;
  assign sum    = {1'b0, t1} + {1'b0, t2} + {{DW{1'b0}}, cin};
  assign nib    = {1'b0, t1[3:0]} + {1'b0, t2[3:0]} + {4'd0, cin};

  always_comb begin
    case (p2_op)
      3'd0:    res = t1;
      3'd1:    res = t2;
      3'd2,
      3'd3:    res = sum[DW-1:0];
      3'd4:    res = t1 & t2;
      3'd5:    res = t1 | t2;
      3'd6:    res = t1 ^ t2;
      default: res = ~t1;
    endcase
  end

  assign fnew = {res[DW-1], res == '0, is_add & nib[4], ~^res, is_add & sum[DW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1 <= '0;
      t2 <= '0;
    end else begin
      if (ld_en && ld_sel_t2)
        t2 <= opnd;
      if (clr_t1)
        t1 <= '0;
      else if (ld_en && !ld_sel_t2)
        t1 <= opnd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p2_cin1    <= 1'b0;
      p2_wb_reg  <= 1'b0;
      p2_wb_dout <= 1'b0;
      p2_op      <= '0;
      p2_addr    <= '0;
      p2_cls     <= '0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
    end else begin
      p2_cin1    <= set_ac;
      p2_wb_reg  <= wb_reg_en;
      p2_wb_dout <= wb_dout;
      p2_op      <= alu_op;
      p2_addr    <= wb_addr;
      p2_cls     <= flag_cls;
      rd_o       <= rd;
      wr_o       <= wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      dout  <= '0;
      flags <= '0;
    end else begin
      if (p2_wb_reg)  bank[p2_addr] <= res;
      if (p2_wb_dout) dout <= res;
      if (p2_cls[0])  flags[4:1] <= fnew[4:1];
      if (p2_cls[1])  flags[0]   <= fnew[0];
    end
  end

endmodule

// File: rtl/uop_exec_chk.sv
module uop_exec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic       wr,
  input logic [1:0] flag_cls,
  input logic [4:0] flags,
  input logic       rd_o,
  input logic       wr_o
);

  p_rd_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rd_o);
  p_rd_quiet_r10:  assert property (@(posedge clk) disable iff (!rst_n) !rd |=> !rd_o);
  p_wr_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n) wr |=> wr_o);
  p_wr_quiet_r10:  assert property (@(posedge clk) disable iff (!rst_n) !wr |=> !wr_o);

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cls == 2'd0) |-> ##2 $stable(flags));

  p_cls_c_keeps_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cls == 2'd2) |-> ##2 (flags[4:1] == $past(flags[4:1])));

  p_cls_r_keeps_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cls == 2'd1) |-> ##2 (flags[0] == $past(flags[0])));

endmodule

bind uop_exec uop_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .flag_cls(flag_cls),
  .flags(flags), .rd_o(rd_o), .wr_o(wr_o)
);

// File: tb/tb_uop_exec.sv
`timescale 1ns/1ps
module tb_uop_exec;

  typedef struct packed {
    logic       ld_en, ld_sel_t2, ld_from_din;
    logic [2:0] rd_addr;
    logic [7:0] din;
    logic       clr_t1, set_ac, io, rd, wr;
    logic [2:0] alu_op;
    logic       wb_reg_en;
    logic [2:0] wb_addr;
    logic       wb_dout;
    logic [1:0] flag_cls;
  } uop_t;

  logic clk = 0, rst_n = 0;
  uop_t u;
  logic [7:0] dout;
  logic [4:0] flags;
  logic rd_o, wr_o, io_o;

  always #5 clk = ~clk;

  uop_exec dut (
    .clk(clk), .rst_n(rst_n), .ld_en(u.ld_en), .ld_sel_t2(u.ld_sel_t2),
    .ld_from_din(u.ld_from_din), .rd_addr(u.rd_addr), .din(u.din),
    .clr_t1(u.clr_t1), .set_ac(u.set_ac), .io(u.io), .rd(u.rd), .wr(u.wr),
    .alu_op(u.alu_op), .wb_reg_en(u.wb_reg_en), .wb_addr(u.wb_addr),
    .wb_dout(u.wb_dout), .flag_cls(u.flag_cls), .dout(dout), .flags(flags),
    .rd_o(rd_o), .wr_o(wr_o), .io_o(io_o)
  );

  // behavioural reference
  int   m_t1, m_t2, m_dout, m_flags, m_rd, m_wr;
  int   m_reg [8];
  uop_t pend [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t1 = 0; m_t2 = 0; m_dout = 0; m_flags = 0; m_rd = 0; m_wr = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      pend.delete();
    end else begin
      uop_t now;
      int nt1, nt2, v;
      now = u;
      nt1 = m_t1; nt2 = m_t2;
      if (now.ld_en) begin
        v = now.ld_from_din ? int'(now.din) : m_reg[now.rd_addr];
        if (now.ld_sel_t2) nt2 = v; else nt1 = v;
      end
      if (now.clr_t1) nt1 = 0;
      if (pend.size() > 0) begin
        uop_t p;
        int r, c, ac, ci, f;
        p = pend.pop_front();
        c = 0; ac = 0;
        case (p.alu_op)
          0: r = m_t1;
          1: r = m_t2;
          2, 3: begin
            ci = (p.alu_op == 2) ? int'(p.set_ac) : (m_flags & 1);
            r  = m_t1 + m_t2 + ci;
            c  = r >> 8;
            ac = ((m_t1 % 16) + (m_t2 % 16) + ci) >> 4;
            r  = r % 256;
          end
          4: r = m_t1 & m_t2;
          5: r = m_t1 | m_t2;
          6: r = m_t1 ^ m_t2;
          default: r = 255 - m_t1;
        endcase
        f = ((r >> 7) << 4) | ((r == 0) << 3) | (ac << 2)
          | (($countones(r[7:0]) % 2 == 0) << 1) | c;
        if (p.flag_cls == 1) m_flags = (f & 30) | (m_flags & 1);
        if (p.flag_cls == 2) m_flags = (m_flags & 30) | (f & 1);
        if (p.flag_cls == 3) m_flags = f;
        if (p.wb_reg_en) m_reg[p.wb_addr] = r;
        if (p.wb_dout) m_dout = r;
      end
      m_t1 = nt1; m_t2 = nt2;
      m_rd = now.rd; m_wr = now.wr;
      pend.push_back(now);
    end
  end

  int    n_run = 0, n_fail = 0;
  string tag = "R11";

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("dout", int'(dout), m_dout);
    chk("flags", int'(flags), m_flags);
    chk("rd_o", int'(rd_o), m_rd);
    chk("wr_o", int'(wr_o), m_wr);
    u = '0;
  endtask

  task automatic issue(uop_t x);
    @(negedge clk);
    chk("dout", int'(dout), m_dout);
    chk("flags", int'(flags), m_flags);
    chk("rd_o", int'(rd_o), m_rd);
    chk("wr_o", int'(wr_o), m_wr);
    u = x;
    #1 chk("io_o", int'(io_o), rst_n ? int'(x.io) : 0);
  endtask

  function automatic uop_t ld(bit t2, bit fdin, int a, int d);
    uop_t x = '0;
    x.ld_en = 1; x.ld_sel_t2 = t2; x.ld_from_din = fdin;
    x.rd_addr = 3'(a); x.din = 8'(d);
    return x;
  endfunction

  function automatic uop_t op(int o, int cls, bit todo, bit wreg, int wa);
    uop_t x = '0;
    x.alu_op = 3'(o); x.flag_cls = 2'(cls);
    x.wb_dout = todo; x.wb_reg_en = wreg; x.wb_addr = 3'(wa);
    return x;
  endfunction

  bit done = 0;

  initial begin
    uop_t x;
    u = '0;
    u.io = 1; u.rd = 1; u.wr = 1; u.ld_en = 1; u.ld_from_din = 1; u.din = 8'hff;
    u.alu_op = 3'd7; u.wb_dout = 1; u.flag_cls = 2'd3;
    tag = "R11";
    repeat (3) step();
    u = '0;
    rst_n = 1;
    step(); step();

    tag = "R1";
    issue(ld(0, 1, 0, 8'h5a));
    issue(op(0, 0, 1, 1, 2));
    issue('0); issue('0);
    issue(ld(1, 0, 2, 0));
    issue(op(1, 0, 1, 0, 0));
    issue('0); issue('0);

    tag = "R3";
    issue(ld(0, 1, 0, 8'h33));
    issue(op(0, 0, 0, 1, 5));
    x = ld(1, 0, 5, 0); issue(x);
    issue(op(1, 0, 1, 0, 0));
    issue(ld(1, 0, 5, 0));
    issue(op(1, 0, 1, 0, 0));
    issue('0); issue('0);

    tag = "R2";
    for (int i = 0; i < 6; i++) begin
      x = ld(0, 1, 0, 16 * i + 3);
      x.alu_op = 3'd0; x.wb_dout = 1;
      issue(x);
    end
    issue('0); issue('0);

    tag = "R4";
    x = ld(0, 1, 0, 8'h77); x.clr_t1 = 1; issue(x);
    issue(op(0, 3, 1, 0, 0));
    issue('0); issue('0);

    tag = "R5";
    issue(ld(0, 1, 0, 8'h0f));
    issue(ld(1, 1, 0, 8'h00));
    x = op(2, 3, 1, 0, 0); x.set_ac = 1; issue(x);
    issue('0); issue('0);

    tag = "R7";
    issue(ld(0, 1, 0, 8'h80));
    issue(ld(1, 1, 0, 8'h80));
    issue(op(2, 3, 1, 0, 0));
    issue('0);
    issue(op(3, 3, 1, 0, 0));
    issue('0); issue('0);

    tag = "R6";
    issue(ld(0, 1, 0, 8'hc3));
    issue(ld(1, 1, 0, 8'h5a));
    for (int o = 0; o < 8; o++) issue(op(o, 3, 1, 0, 0));
    issue('0); issue('0);

    tag = "R8";
    issue(ld(0, 1, 0, 8'hff));
    issue(ld(1, 1, 0, 8'h01));
    issue(op(2, 2, 1, 0, 0));
    issue(op(7, 1, 1, 0, 0));
    issue(op(4, 1, 1, 0, 0));
    issue(op(2, 1, 1, 0, 0));
    issue('0); issue('0);

    tag = "R9";
    issue(op(7, 0, 1, 0, 0));
    issue(op(2, 0, 1, 0, 0));
    issue('0); issue('0);

    tag = "R10";
    x = '0; x.rd = 1; issue(x);
    x = '0; x.wr = 1; x.io = 1; issue(x);
    x = '0; x.io = 1; x.rd = 1; x.wr = 1; issue(x);
    issue('0); issue('0);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      x = uop_t'({$urandom, $urandom});
      issue(x);
    end
    issue('0); issue('0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule